// File: doc/BRIEF.md
# Serial Asynchronous Transmitter with Queued Idle

This block turns bytes written by a host into asynchronous serial frames on a single output line. A frame is a low start bit, 8 or 9 data bits sent least significant first, and a high stop bit. Each bit lasts 16 pulses of an external baud tick. When hardware parity is on, the top data bit is replaced by a computed parity bit, so the frame does not grow. A one-entry holding register sits in front of the shift register, which lets a host keep the line busy with no gaps between frames.

The enable input does more than gate data. Taking it low and then high again while a frame is on the line queues one idle frame, which is a full frame of mark bits. A break request queues a frame held low for the whole frame length, followed by one mark bit. When the enable drops, the pin-ownership output stays asserted until the current frame and any queued idle or break have finished. Two status flags report the block's state: one says the holding register is empty, the other says the whole transmitter is quiet. Each flag has an interrupt request that its own enable gates. Two mode inputs (internal loopback, and a shared single line with a direction input) decide whether the block drives the external pin at all.

Top module: `uart_tx_qidle`

## Requirements
- R1: After reset, txd is 1, tdre is 1, tc is 1, and txd_oe, tx_irq and tc_irq are 0.
- R2: A data frame is one 0 start bit, then 8 data bits (nine_bit=0) or 9 data bits (nine_bit=1), least significant first, then one 1 stop bit. Every bit lasts 16 baud ticks.
- R3: With par_en=1, the last data bit on the line (bit 7 in 8-bit mode, bit 8 in 9-bit mode) is replaced by a parity bit. With par_odd=0 the total count of ones across the data bits including parity is even. With par_odd=1 that count is odd. The frame length does not change.
- R4: With par_en=0, every data bit, including the top one, is sent exactly as written.
- R5: A host write clears tdre on the next clock edge. tdre sets again when the held byte moves into the shift register. A byte written while a frame is in flight starts exactly 16*(frame bits) ticks after the previous start, with no gap.
- R6: tc is 1 only when no frame is in flight, the holding register is empty, and no idle or break is queued. Whenever tc is 1, txd is 1.
- R7: A 0 to 1 transition on tx_en while a frame is in flight queues one idle frame of all mark bits, with the same length as a data frame. It goes out before any held data.
- R8: While tx_en is 0, held data does not start. The frame in flight still completes, and txd_oe stays 1 until it ends and then falls.
- R9: A brk_req pulse queues a break: txd low for a full frame length, then one mark bit. At a frame boundary the next frame is chosen in this order: queued idle first, then break, then held data.
- R10: tx_irq is the registered value of tdre AND tx_int_en. tc_irq is the registered value of tc AND tc_int_en. Each follows its inputs after one clock.
- R11: txd_oe is 0 one clock after loop_mode=1 with single_wire=0. With single_wire=1 it follows wire_dir_out. Otherwise it is 1 while tx_en is 1 or any output is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Baud pulse, 16 per bit time |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 9 | Byte to send; bit 8 is used only in 9-bit mode |
| nine_bit | input | 1 | 1 selects 9 data bits per frame |
| par_en | input | 1 | 1 enables hardware parity on the top data bit |
| par_odd | input | 1 | Parity type: 0 even, 1 odd |
| tx_en | input | 1 | Transmit enable; a rising edge during a frame queues idle |
| brk_req | input | 1 | One-cycle request to queue a break |
| tx_int_en | input | 1 | Enable for the holding-register-empty interrupt |
| tc_int_en | input | 1 | Enable for the transmit-complete interrupt |
| loop_mode | input | 1 | Internal loopback: the block releases the pin |
| single_wire | input | 1 | Shared single-line mode |
| wire_dir_out | input | 1 | In single-line mode, 1 means the block drives the line |
| txd | output | 1 | Serial data output |
| txd_oe | output | 1 | Pin ownership, registered |
| tdre | output | 1 | Holding register empty flag |
| tc | output | 1 | Transmitter quiet flag |
| tx_irq | output | 1 | Interrupt request for tdre |
| tc_irq | output | 1 | Interrupt request for tc |

## Verification
At a frame boundary, several things can be ready for the same shift slot: a queued idle, a queued break and a held byte. The bench provokes this by raising brk_req, pulsing tx_en low for one cycle and writing a byte, all while one frame is still in flight. It then judges the order and spacing on the line. The break must start two frame lengths after the first frame, because the idle goes first, and the byte must follow one break length later. A second case writes a byte while the shifter is busy, so the write and a later load compete for the holding register. Here the bench checks the start-to-start spacing of the frames.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_IDLE  = 2'd1,
    K_BREAK = 2'd2,
    K_DATA  = 2'd3
  } load_kind_t;
endpackage

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DATA_MAX  = 9,
  parameter int FRAME_MAX = DATA_MAX + 3,
  parameter int NB_W      = $clog2(FRAME_MAX + 1)
) (
  input  logic [DATA_MAX-1:0]  data,
  input  logic                 nine_bit,
  input  logic                 par_en,
  input  logic                 par_odd,
  input  load_kind_t           kind,
  output logic [FRAME_MAX-1:0] frame,
  output logic [NB_W-1:0]      nbits
);
  localparam int DATA_MIN = DATA_MAX - 1;

  int  n_data;
  logic par_bit;

  always_comb begin
    n_data  = nine_bit ? DATA_MAX : DATA_MIN;
    par_bit = par_odd;
    for (int i = 0; i < DATA_MAX - 1; i++) begin
      if (i < n_data - 1) par_bit = par_bit ^ data[i];
    end
  end

  always_comb begin
    frame = '1;
    nbits = NB_W'(n_data + 2);
    unique case (kind)
      K_DATA: begin
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
          if (i < n_data) frame[i+1] = data[i];
        end
        if (par_en) frame[n_data] = par_bit;
      end
      K_BREAK: begin
        for (int i = 0; i < FRAME_MAX; i++) frame[i] = (i >= n_data + 2);
        nbits = NB_W'(n_data + 3);
      end
      default: frame = '1;
    endcase
  end
endmodule

// File: rtl/uart_tx_queue.sv
module uart_tx_queue
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_en,
  input  logic       brk_req,
  input  logic       busy,
  input  logic       held_full,
  input  logic       fire,
  output load_kind_t kind,
  output logic       idle_pend,
  output logic       brk_pend
);
  logic en_d;

  always_comb begin
    if (idle_pend)              kind = K_IDLE;
    else if (brk_pend)          kind = K_BREAK;
    else if (tx_en && held_full) kind = K_DATA;
    else                        kind = K_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d      <= 1'b0;
      idle_pend <= 1'b0;
      brk_pend  <= 1'b0;
    end else begin
      en_d <= tx_en;
      if (tx_en && !en_d && busy)          idle_pend <= 1'b1;
      else if (fire && kind == K_IDLE)     idle_pend <= 1'b0;
      if (brk_req)                         brk_pend  <= 1'b1;
      else if (fire && kind == K_BREAK)    brk_pend  <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int FRAME_MAX     = 12,
  parameter int TICKS_PER_BIT = 16,
  parameter int NB_W          = $clog2(FRAME_MAX + 1),
  parameter int TK_W          = $clog2(TICKS_PER_BIT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 baud_tick,
  input  logic                 load_en,
  input  logic [FRAME_MAX-1:0] frame,
  input  logic [NB_W-1:0]      nbits,
  output logic                 accept,
  output logic                 busy,
  output logic                 txd
);
  localparam logic [TK_W-1:0] TK_LAST  = TK_W'(TICKS_PER_BIT - 1);
  localparam logic [NB_W-1:0] LAST_BIT = NB_W'(1);

  logic [FRAME_MAX-1:0] shreg;
  logic [NB_W-1:0]      bits_left;
  logic [TK_W-1:0]      tick_cnt;
  logic                 bit_end;

  assign bit_end = busy && baud_tick && (tick_cnt == TK_LAST);
  assign accept  = !busy || (bit_end && bits_left == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      shreg     <= '1;
      bits_left <= '0;
      tick_cnt  <= '0;
      txd       <= 1'b1;
    end else if (load_en) begin
      busy      <= 1'b1;
      shreg     <= frame;
      bits_left <= nbits;
      tick_cnt  <= '0;
      txd       <= frame[0];
    end else if (busy && baud_tick) begin
      if (bit_end) begin
        tick_cnt <= '0;
        if (bits_left == LAST_BIT) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          shreg     <= {1'b1, shreg[FRAME_MAX-1:1]};
          txd       <= shreg[1];
          bits_left <= bits_left - NB_W'(1);
        end
      end else begin
        tick_cnt <= tick_cnt + TK_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_tx_qidle.sv
module uart_tx_qidle
  import uart_tx_pkg::*;
#(
  parameter int DATA_MAX      = 9,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                baud_tick,
  input  logic                wr_en,
  input  logic [DATA_MAX-1:0] wr_data,
  input  logic                nine_bit,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                tx_en,
  input  logic                brk_req,
  input  logic                tx_int_en,
  input  logic                tc_int_en,
  input  logic                loop_mode,
  input  logic                single_wire,
  input  logic                wire_dir_out,
  output logic                txd,
  output logic                txd_oe,
  output logic                tdre,
  output logic                tc,
  output logic                tx_irq,
  output logic                tc_irq
);
  localparam int FRAME_MAX = DATA_MAX + 3;
  localparam int NB_W      = $clog2(FRAME_MAX + 1);

  logic [DATA_MAX-1:0]  held;
  logic                 accept, busy, fire;
  logic                 idle_pend, brk_pend;
  load_kind_t           kind;
  logic [FRAME_MAX-1:0] frame;
  logic [NB_W-1:0]      nbits;
  logic                 own_ok, want_pin;

  assign fire = accept && (kind != K_NONE);

  uart_tx_queue q_i (
    .clk(clk), .rst(rst), .tx_en(tx_en), .brk_req(brk_req), .busy(busy),
    .held_full(!tdre), .fire(fire), .kind(kind),
    .idle_pend(idle_pend), .brk_pend(brk_pend)
  );

  uart_tx_framer #(.DATA_MAX(DATA_MAX), .FRAME_MAX(FRAME_MAX), .NB_W(NB_W)) fr_i (
    .data(held), .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd),
    .kind(kind), .frame(frame), .nbits(nbits)
  );

  uart_tx_shifter #(.FRAME_MAX(FRAME_MAX), .TICKS_PER_BIT(TICKS_PER_BIT), .NB_W(NB_W)) sh_i (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .load_en(fire), .frame(frame),
    .nbits(nbits), .accept(accept), .busy(busy), .txd(txd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
      tdre <= 1'b1;
    end else if (wr_en) begin
      held <= wr_data;
      tdre <= 1'b0;
    end else if (fire && kind == K_DATA) begin
      tdre <= 1'b1;
    end
  end

  assign tc = !busy && tdre && !idle_pend && !brk_pend;

  always_comb begin
    want_pin = tx_en || busy || idle_pend || brk_pend;
    if (single_wire)    own_ok = wire_dir_out;
    else if (loop_mode) own_ok = 1'b0;
    else                own_ok = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txd_oe <= 1'b0;
      tx_irq <= 1'b0;
      tc_irq <= 1'b0;
    end else begin
      txd_oe <= want_pin && own_ok;
      tx_irq <= tdre && tx_int_en;
      tc_irq <= tc && tc_int_en;
    end
  end
endmodule

// File: rtl/uart_tx_qidle_chk.sv
module uart_tx_qidle_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic tx_int_en,
  input logic tc_int_en,
  input logic loop_mode,
  input logic single_wire,
  input logic txd,
  input logic txd_oe,
  input logic tdre,
  input logic tc,
  input logic tx_irq,
  input logic tc_irq
);
  assert_wr_clears_ready_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !tdre);

  assert_quiet_line_mark_R6: assert property (@(posedge clk) disable iff (rst)
    tc |-> txd);

  assert_txirq_gated_R10: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> ($past(tx_int_en) && $past(tdre)));

  assert_tcirq_gated_R10: assert property (@(posedge clk) disable iff (rst)
    tc_irq |-> ($past(tc_int_en) && $past(tc)));

  assert_loop_releases_pin_R11: assert property (@(posedge clk) disable iff (rst)
    (loop_mode && !single_wire) |=> !txd_oe);
endmodule

bind uart_tx_qidle uart_tx_qidle_chk chk_i (.*);

// File: tb/uart_tx_qidle_tb_top.sv
`timescale 1ns/1ps
module uart_tx_qidle_tb_top;
  localparam int TPB      = 16;
  localparam int WD_LIMIT = 150000;

  typedef struct {
    logic [8:0] wire_val;
    bit         nine;
    bit         stop;
    int         gap;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic baud_tick = 1'b1;
  logic wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic nine_bit = 1'b0, par_en = 1'b0, par_odd = 1'b0, tx_en = 1'b0, brk_req = 1'b0;
  logic tx_int_en = 1'b0, tc_int_en = 1'b0, loop_mode = 1'b0, single_wire = 1'b0, wire_dir_out = 1'b0;
  logic txd, txd_oe, tdre, tc, tx_irq, tc_irq;

  int cyc = 0, checks = 0, errors = 0;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  uart_tx_qidle dut_i (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
    .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd), .tx_en(tx_en),
    .brk_req(brk_req), .tx_int_en(tx_int_en), .tc_int_en(tc_int_en),
    .loop_mode(loop_mode), .single_wire(single_wire), .wire_dir_out(wire_dir_out),
    .txd(txd), .txd_oe(txd_oe), .tdre(tdre), .tc(tc), .tx_irq(tx_irq), .tc_irq(tc_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [8:0] exp_wire(input logic [8:0] d, input bit nine, input bit pe, input bit po);
    logic [8:0] w;
    int n, ones;
    n = nine ? 9 : 8;
    w = nine ? d : {1'b0, d[7:0]};
    ones = 0;
    if (pe) begin
      for (int i = 0; i < n - 1; i++) ones += int'(w[i]);
      w[n-1] = po ? ((ones % 2) == 0) : ((ones % 2) == 1);
    end
    return w;
  endfunction

  task automatic push(input logic [8:0] w, input bit nine, input bit stop, input int gap, input string tag);
    item_t it;
    it.wire_val = w; it.nine = nine; it.stop = stop; it.gap = gap; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic send(input logic [8:0] d, input int gap, input string tag);
    while (!tdre) @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    push(exp_wire(d, nine_bit, par_en, par_odd), nine_bit, 1'b1, gap, tag);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_loaded();
    @(negedge clk);
    while (!tdre) @(negedge clk);
  endtask

  task automatic wait_quiet();
    @(negedge clk);
    while (!tc) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic toggle_en();
    tx_en = 1'b0;
    @(negedge clk);
    tx_en = 1'b1;
    @(negedge clk);
  endtask

  // monitor: decode frames at bit centres and compare against the scoreboard
  initial begin : monitor
    logic prev;
    int sc, last_start, n;
    item_t it;
    logic [11:0] got, expv;
    prev = 1'b1;
    last_start = -1;
    forever begin
      @(negedge clk);
      if (!rst && prev && !txd) begin
        sc = cyc;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected frame", sc, -1);
        end else begin
          it = exp_q.pop_front();
          n = it.nine ? 9 : 8;
          got = '0;
          expv = '0;
          repeat (TPB / 2) @(negedge clk);
          got[0] = txd;
          for (int i = 1; i <= n + 1; i++) begin
            repeat (TPB) @(negedge clk);
            got[i] = txd;
          end
          for (int i = 0; i < n; i++) expv[i+1] = it.wire_val[i];
          expv[n+1] = it.stop;
          chk(got == expv, {it.tag, " frame bits"}, int'(got), int'(expv));
          if (it.gap > 0 && last_start >= 0)
            chk((sc - last_start) == it.gap, {it.tag, " start spacing"}, sc - last_start, it.gap);
          last_start = sc;
        end
      end
      prev = txd;
    end
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd", int'(txd), 1);
    chk(tdre == 1'b1, "R1 tdre", int'(tdre), 1);
    chk(tc == 1'b1, "R1 tc", int'(tc), 1);
    chk(txd_oe == 1'b0, "R1 txd_oe", int'(txd_oe), 0);
    chk((tx_irq | tc_irq) == 1'b0, "R1 irqs", int'({tx_irq, tc_irq}), 0);

    // R5 / R8: a held byte with the enable off
    send(9'h0A5, 0, "R2");
    @(negedge clk);
    chk(tdre == 1'b0, "R5 tdre after write", int'(tdre), 0);
    chk(tc == 1'b0, "R6 tc with held data", int'(tc), 0);
    chk(txd_oe == 1'b0, "R8 no pin without enable", int'(txd_oe), 0);
    chk(txd == 1'b1, "R8 held data not started", int'(txd), 1);

    // R2 / R5: back-to-back 8-bit frames
    tx_en = 1'b1;
    send(9'h03C, 10 * TPB, "R5");
    send(9'h081, 10 * TPB, "R5");
    repeat (5) @(negedge clk);
    chk(tc == 1'b0, "R6 tc while busy", int'(tc), 0);
    wait_quiet();
    chk(tc == 1'b1 && txd == 1'b1, "R6 quiet line", int'({tc, txd}), 3);

    // R3: parity in 8-bit and 9-bit modes
    par_en = 1'b1; par_odd = 1'b0;
    send(9'h053, 0, "R3");
    send(9'h007, 10 * TPB, "R3");
    wait_quiet();
    par_odd = 1'b1;
    send(9'h053, 0, "R3");
    send(9'h0FF, 10 * TPB, "R3");
    wait_quiet();
    nine_bit = 1'b1;
    send(9'h0AB, 0, "R3");
    send(9'h155, 11 * TPB, "R3");
    wait_quiet();
    // R4: nine bits, no parity, top bit kept
    par_en = 1'b0;
    send(9'h1F0, 0, "R4");
    send(9'h101, 11 * TPB, "R4");
    wait_quiet();
    nine_bit = 1'b0;
    send(9'h080, 0, "R4");
    wait_quiet();

    // R7: enable toggle during a frame queues one idle frame
    send(9'h05A, 0, "R7");
    wait_loaded();
    send(9'h066, 2 * 10 * TPB, "R7");
    toggle_en();
    wait_quiet();

    // R8: enable dropped during a frame
    send(9'h011, 0, "R8");
    wait_loaded();
    send(9'h022, 0, "R8");
    tx_en = 1'b0;
    repeat (40) @(negedge clk);
    chk(txd_oe == 1'b1, "R8 pin held mid frame", int'(txd_oe), 1);
    repeat (10 * TPB) @(negedge clk);
    chk(txd_oe == 1'b0, "R8 pin released", int'(txd_oe), 0);
    chk(tdre == 1'b0 && txd == 1'b1, "R8 held byte waits", int'({tdre, txd}), 1);
    tx_en = 1'b1;
    wait_quiet();

    // R9: idle, break and data all queued behind one frame
    send(9'h099, 0, "R9");
    wait_loaded();
    brk_req = 1'b1;
    @(negedge clk);
    brk_req = 1'b0;
    toggle_en();
    push(9'h000, 1'b0, 1'b0, 2 * 10 * TPB, "R9");
    send(9'h044, 11 * TPB, "R9");
    wait_quiet();

    // R10: interrupt gating
    tx_int_en = 1'b1; tc_int_en = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx_irq == 1'b1, "R10 tx_irq on", int'(tx_irq), 1);
    chk(tc_irq == 1'b1, "R10 tc_irq on", int'(tc_irq), 1);
    tx_int_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(tx_irq == 1'b0, "R10 tx_irq masked", int'(tx_irq), 0);
    send(9'h0C3, 0, "R10");
    repeat (5) @(negedge clk);
    chk(tc_irq == 1'b0, "R10 tc_irq while busy", int'(tc_irq), 0);
    wait_quiet();
    chk(tc_irq == 1'b1, "R10 tc_irq after frame", int'(tc_irq), 1);

    // R11: pin ownership modes
    loop_mode = 1'b1;
    repeat (2) @(negedge clk);
    chk(txd_oe == 1'b0, "R11 loopback", int'(txd_oe), 0);
    single_wire = 1'b1; wire_dir_out = 1'b0;
    repeat (2) @(negedge clk);
    chk(txd_oe == 1'b0, "R11 single wire in", int'(txd_oe), 0);
    wire_dir_out = 1'b1;
    repeat (2) @(negedge clk);
    chk(txd_oe == 1'b1, "R11 single wire out", int'(txd_oe), 1);
    loop_mode = 1'b0; single_wire = 1'b0;
    repeat (2) @(negedge clk);
    chk(txd_oe == 1'b1, "R11 normal", int'(txd_oe), 1);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all frames seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule